// File: doc/BRIEF.md
# Float to Signed Integer Converter

This unit turns one IEEE-754 binary floating-point value into a signed two's-complement integer. The source may be half, single or double precision, chosen by a two-bit format code. The result is either 32 or 64 bits wide, chosen by a width bit. The operand always travels on a 64-bit bus, and narrower formats sit in its least significant bits. Rounding is always to the nearest integer, and exact halfway cases go to the even neighbour.

Each conversion is launched by a one-cycle valid strobe. Exactly one clock later the unit presents the integer result, an invalid-operation flag and an inexact flag, together with an output-valid pulse. Values that cannot be represented do not trap. Such values are NaNs, infinities, anything whose rounded value falls outside the selected width, and operands carrying the unused format code. Each of them sets the invalid flag and returns a defined substitute value, so the surrounding pipeline can decide what to do with it.

Top module: `fp2int_rne`

## Requirements
- R1: Rounding is to nearest. A value exactly halfway between two integers goes to the even one, so 2.5 gives 2, 3.5 gives 4, 100.5 gives 100 and -2.5 gives -2.
- R2: The format code `fmt` selects the source precision: 2'b00 is single (8 exponent bits, 23 fraction bits), 2'b01 is double (11 and 52), and 2'b11 is half (5 and 10). A narrower format is read from `operand[15:0]` or `operand[31:0]`, and the bits above it are ignored.
- R3: `wide`=1 gives a 64-bit two's-complement result on `result[63:0]`. `wide`=0 gives a 32-bit two's-complement result on `result[31:0]`, with `result[63:32]` driven to zero.
- R4: If the rounded value is above the largest or below the smallest signed integer of the selected width, `invalid` is raised. The result then saturates to that width's most positive value (0x7FFFFFFF or 0x7FFFFFFFFFFFFFFF) or most negative value (0x80000000 or 0x8000000000000000).
- R5: A NaN input raises `invalid` and returns zero.
- R6: An infinity raises `invalid` and saturates as in R4, according to its sign.
- R7: Positive and negative zero return 0 with no flag raised. Subnormal inputs return 0 and raise `inexact`.
- R8: `inexact` is raised exactly when the rounded integer differs from the input value. It is never raised together with `invalid`.
- R9: The unused format code 2'b10 raises `invalid`, clears `inexact` and returns zero.
- R10: `out_valid` pulses one cycle after each `in_valid`, carrying that operand's result and flags. Without `in_valid`, the result and flags hold their last values.
- R11: While reset is asserted, `out_valid`, `result`, `invalid` and `inexact` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Launches a conversion of the current operand |
| operand | input | 64 | Floating-point bits, right-aligned for narrow formats |
| fmt | input | 2 | Source format code (R2) |
| wide | input | 1 | Result width: 0 for 32-bit, 1 for 64-bit |
| out_valid | output | 1 | Result and flags are valid this cycle |
| result | output | 64 | Signed integer result |
| invalid | output | 1 | Invalid-operation flag |
| inexact | output | 1 | Inexact flag |

## Verification
The hardest cases to reach from the ports are ties that sit right at a width boundary. One example is 2147483647.5 in 32-bit mode. It must round up to an even value that no longer fits, and so turns a tie into an overflow. Its neighbour 2147483646.5 must round down and stay in range. The stimulus builds these double-precision bit patterns by hand, next to powers of two that land exactly on the most negative integer (-2^31 and -2^63). This way both sides of the asymmetric signed limit are exercised in each width.

// File: rtl/fp2int_pkg.sv
package fp2int_pkg;

  localparam int MANT_W = 53;
  localparam int EXPV_W = 13;

  typedef enum logic [1:0] {
    FMT_SGL = 2'b00,
    FMT_DBL = 2'b01,
    FMT_RSV = 2'b10,
    FMT_HLF = 2'b11
  } fp_fmt_e;

  typedef struct packed {
    logic                sign;
    logic                is_zero;
    logic                is_sub;
    logic                is_inf;
    logic                is_nan;
    logic                bad_fmt;
    logic [EXPV_W-1:0]   exp;   // unbiased, two's complement
    logic [MANT_W-1:0]   mant;  // hidden bit at MANT_W-1
  } fp_unpacked_t;

  // round-to-nearest-even increment decision
  function automatic logic rne_up(input logic lsb, input logic half, input logic sticky);
    return half & (sticky | lsb);
  endfunction

  function automatic logic is_finite_normal(input fp_unpacked_t u);
    return !(u.is_zero | u.is_sub | u.is_inf | u.is_nan | u.bad_fmt);
  endfunction

endpackage

// File: rtl/fp2int_field_dec.sv
module fp2int_field_dec
  import fp2int_pkg::*;
#(
  parameter int EB = 8,
  parameter int FB = 23
) (
  input  logic [EB+FB:0]  raw,
  output fp_unpacked_t    up
);
  localparam int BIAS = (1 << (EB - 1)) - 1;

  logic [EB-1:0] expf;
  logic [FB-1:0] frac;
  logic          e_ones;
  logic          e_zero;
  logic          f_zero;

  assign expf   = raw[EB+FB-1:FB];
  assign frac   = raw[FB-1:0];
  assign e_ones = &expf;
  assign e_zero = ~|expf;
  assign f_zero = ~|frac;

  always_comb begin
    up         = '0;
    up.sign    = raw[EB+FB];
    up.is_zero = e_zero & f_zero;
    up.is_sub  = e_zero & ~f_zero;
    up.is_inf  = e_ones & f_zero;
    up.is_nan  = e_ones & ~f_zero;
    up.bad_fmt = 1'b0;
    up.exp     = EXPV_W'(expf) - EXPV_W'(BIAS);
    up.mant    = MANT_W'({1'b1, frac}) << (MANT_W - 1 - FB);
  end
endmodule

// File: rtl/fp2int_unpack.sv
module fp2int_unpack
  import fp2int_pkg::*;
#(
  parameter int OP_W = 64
) (
  input  logic [OP_W-1:0] operand,
  input  logic [1:0]      fmt,
  output fp_unpacked_t    up
);
  localparam int NFMT = 3;
  localparam int EB_TAB [NFMT] = '{8, 11, 5};
  localparam int FB_TAB [NFMT] = '{23, 52, 10};

  fp_unpacked_t dec [NFMT];

  for (genvar g = 0; g < NFMT; g++) begin : g_dec
    localparam int EB = EB_TAB[g];
    localparam int FB = FB_TAB[g];
    fp2int_field_dec #(.EB(EB), .FB(FB)) u_dec (
      .raw (operand[EB+FB:0]),
      .up  (dec[g])
    );
  end

  always_comb begin
    case (fp_fmt_e'(fmt))
      FMT_SGL: up = dec[0];
      FMT_DBL: up = dec[1];
      FMT_HLF: up = dec[2];
      default: begin
        up         = '0;
        up.bad_fmt = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/fp2int_round.sv
module fp2int_round
  import fp2int_pkg::*;
#(
  parameter int INT_W = 64
) (
  input  fp_unpacked_t    up,
  output logic [INT_W:0]  mag,
  output logic            lost,
  output logic            huge,
  output logic            tie_evt
);
  localparam int FX_W = 2 * INT_W;
  localparam int SH_W = $clog2(INT_W);

  logic                    normal;
  logic signed [EXPV_W-1:0] e;
  logic                    in_shift;
  logic                    at_half;
  logic                    tiny;
  logic [FX_W-1:0]         f0;
  logic [FX_W-1:0]         fx;
  logic [INT_W-1:0]        ipart;
  logic                    half_b;
  logic                    sticky_b;

  assign normal   = is_finite_normal(up);
  assign e        = $signed(up.exp);
  assign huge     = normal && (e >= EXPV_W'(INT_W));
  assign in_shift = normal && (e >= 0) && !huge;
  assign at_half  = normal && (e == -1);
  assign tiny     = normal && (e < -1);

  // hidden bit lands on the weight-one position of a 64.64 fixed point word
  assign f0 = FX_W'(up.mant) << (INT_W - (MANT_W - 1));

  always_comb begin
    if (in_shift)     fx = f0 << e[SH_W-1:0];
    else if (at_half) fx = f0 >> 1;
    else              fx = '0;
  end

  assign ipart    = fx[FX_W-1:INT_W];
  assign half_b   = fx[INT_W-1];
  assign sticky_b = |fx[INT_W-2:0];

  always_comb begin
    mag  = {1'b0, ipart} + (INT_W+1)'(rne_up(ipart[0], half_b, sticky_b));
    lost = half_b | sticky_b | tiny;
  end

  assign tie_evt = (in_shift | at_half) & half_b & ~sticky_b;
endmodule

// File: rtl/fp2int_clamp.sv
module fp2int_clamp #(
  parameter int INT_W    = 64,
  parameter int NARROW_W = 32
) (
  input  logic             sign,
  input  logic             wide,
  input  logic [INT_W:0]   mag,
  input  logic             huge,
  input  logic             lost,
  input  logic             is_nan,
  input  logic             is_inf,
  input  logic             is_sub,
  input  logic             bad_fmt,
  output logic             out_of_range,
  output logic [INT_W-1:0] value,
  output logic             inv,
  output logic             inx
);
  logic [INT_W:0]   lim;
  logic             mag_over;
  logic [INT_W-1:0] signed_full;
  logic [INT_W-1:0] sat_pos;
  logic [INT_W-1:0] sat_neg;
  logic [INT_W-1:0] fit_val;

  // magnitude of the most negative integer of the selected width
  assign lim = wide ? ((INT_W+1)'(1) << (INT_W - 1)) : ((INT_W+1)'(1) << (NARROW_W - 1));

  assign mag_over     = sign ? (mag > lim) : (mag >= lim);
  assign out_of_range = huge | is_inf | mag_over;

  assign signed_full = sign ? (~mag[INT_W-1:0] + INT_W'(1)) : mag[INT_W-1:0];

  assign sat_pos = wide ? {1'b0, {(INT_W-1){1'b1}}}
                        : INT_W'({1'b0, {(NARROW_W-1){1'b1}}});
  assign sat_neg = wide ? {1'b1, {(INT_W-1){1'b0}}}
                        : INT_W'({1'b1, {(NARROW_W-1){1'b0}}});
  assign fit_val = wide ? signed_full : INT_W'(signed_full[NARROW_W-1:0]);

  always_comb begin
    if (is_nan | bad_fmt)  value = '0;
    else if (out_of_range) value = sign ? sat_neg : sat_pos;
    else                   value = fit_val;
  end

  assign inv = is_nan | bad_fmt | out_of_range;
  assign inx = ~inv & (lost | is_sub);
endmodule

// File: rtl/fp2int_rne.sv
module fp2int_rne
  import fp2int_pkg::*;
#(
  parameter int INT_W    = 64,
  parameter int NARROW_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [63:0]      operand,
  input  logic [1:0]       fmt,
  input  logic             wide,
  output logic             out_valid,
  output logic [INT_W-1:0] result,
  output logic             invalid,
  output logic             inexact
);
  fp_unpacked_t     up;
  logic [INT_W:0]   mag;
  logic             lost;
  logic             huge;
  logic             tie_evt;
  logic             ovf_evt;
  logic [INT_W-1:0] val_c;
  logic             inv_c;
  logic             inx_c;

  fp2int_unpack #(.OP_W(64)) u_unpack (
    .operand (operand),
    .fmt     (fmt),
    .up      (up)
  );

  fp2int_round #(.INT_W(INT_W)) u_round (
    .up      (up),
    .mag     (mag),
    .lost    (lost),
    .huge    (huge),
    .tie_evt (tie_evt)
  );

  fp2int_clamp #(.INT_W(INT_W), .NARROW_W(NARROW_W)) u_clamp (
    .sign         (up.sign),
    .wide         (wide),
    .mag          (mag),
    .huge         (huge),
    .lost         (lost),
    .is_nan       (up.is_nan),
    .is_inf       (up.is_inf),
    .is_sub       (up.is_sub),
    .bad_fmt      (up.bad_fmt),
    .out_of_range (ovf_evt),
    .value        (val_c),
    .inv          (inv_c),
    .inx          (inx_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      invalid   <= 1'b0;
      inexact   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= val_c;
        invalid <= inv_c;
        inexact <= inx_c;
      end
    end
  end

  // R10: one-cycle latency and hold while idle
  p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(invalid) && $stable(inexact)));

  // R3: narrow results leave the upper half clear
  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide) |=> (result[INT_W-1:NARROW_W] == '0));

  // R1: an in-range tie always lands on an even integer
  p_tie_even_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && tie_evt && !ovf_evt) |=> !result[0]);

  // R4 / R6: out-of-range values flag and saturate to a non-zero limit
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ovf_evt) |=> (invalid && !inexact && result != '0));

  // R5: NaN gives zero with the invalid flag
  p_nan_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && up.is_nan) |=> (invalid && result == '0));

  // R7: zeros are clean
  p_zero_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && up.is_zero) |=> (result == '0 && !invalid && !inexact));

  // R8: the two flags never appear together
  p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(invalid && inexact));

  // R9: the unused format code is rejected
  p_reserved_fmt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt == 2'b10) |=> (invalid && !inexact && result == '0));

endmodule

// File: tb/fp2int_rne_test.sv
module fp2int_rne_test;

  typedef struct {
    logic [63:0] res;
    logic        inv;
    logic        inx;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] operand = '0;
  logic [1:0]  fmt = '0;
  logic        wide = 1'b0;
  logic        out_valid;
  logic [63:0] result;
  logic        invalid;
  logic        inexact;

  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done     = 1'b0;
  exp_t sb [$];
  logic [63:0] last_res = '0;

  localparam logic [1:0] SGL = 2'b00, DBL = 2'b01, RSV = 2'b10, HLF = 2'b11;

  always #10 clk = ~clk;

  fp2int_rne uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .operand   (operand),
    .fmt       (fmt),
    .wide      (wide),
    .out_valid (out_valid),
    .result    (result),
    .invalid   (invalid),
    .inexact   (inexact)
  );

  task automatic check(input string tag, input logic [63:0] gr, input logic gi, input logic gx,
                       input logic [63:0] er, input logic ei, input logic ex);
    n_checks++;
    if (gr !== er || gi !== ei || gx !== ex) begin
      n_fails++;
      $display("FAIL %s: got res=%h inv=%b inx=%b, expected res=%h inv=%b inx=%b",
               tag, gr, gi, gx, er, ei, ex);
    end
  endtask

  task automatic send(input logic [63:0] op, input logic [1:0] f, input logic w,
                      input logic [63:0] er, input logic ei, input logic ex, input string tag);
    exp_t item;
    @(negedge clk);
    operand  = op;
    fmt      = f;
    wide     = w;
    in_valid = 1'b1;
    item.res = er; item.inv = ei; item.inx = ex; item.tag = tag;
    sb.push_back(item);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: compares each produced result with the oldest expected item
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (sb.size() == 0) begin
          n_checks++;
          n_fails++;
          $display("FAIL R10: out_valid with nothing outstanding, got res=%h expected none", result);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.tag, result, invalid, inexact, e.res, e.inv, e.inx);
          last_res = e.res;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run hung, got no finish, expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    // R11: reset state
    in_valid = 1'b1;
    operand  = 64'h3F80_0000;
    repeat (3) @(negedge clk);
    check("R11", result, invalid, inexact, 64'h0, 1'b0, 1'b0);
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_fails++;
      $display("FAIL R11: out_valid=%b expected 0", out_valid);
    end
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R1: ties to even, single precision
    send(64'h4020_0000, SGL, 1'b0, 64'h2, 1'b0, 1'b1, "R1");
    send(64'h4060_0000, SGL, 1'b0, 64'h4, 1'b0, 1'b1, "R1");
    send(64'h42C9_0000, SGL, 1'b1, 64'd100, 1'b0, 1'b1, "R1");
    send(64'h42CB_0000, SGL, 1'b1, 64'd102, 1'b0, 1'b1, "R1");
    send(64'h3F00_0000, SGL, 1'b0, 64'h0, 1'b0, 1'b1, "R1");
    send(64'h3FC0_0000, SGL, 1'b0, 64'h2, 1'b0, 1'b1, "R1");
    // R8: non-tie rounding and exact values
    send(64'h3F40_0000, SGL, 1'b0, 64'h1, 1'b0, 1'b1, "R8");
    send(64'h3F80_0000, SGL, 1'b0, 64'h1, 1'b0, 1'b0, "R8");
    // R3: negative results in both widths
    send(64'hC020_0000, SGL, 1'b0, 64'h0000_0000_FFFF_FFFE, 1'b0, 1'b1, "R3");
    send(64'hC020_0000, SGL, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b1, "R3");
    send(64'hCF00_0000, SGL, 1'b0, 64'h0000_0000_8000_0000, 1'b0, 1'b0, "R3");
    send(64'h4F00_0000, SGL, 1'b1, 64'h0000_0000_8000_0000, 1'b0, 1'b0, "R3");
    // R4: overflow saturation
    send(64'h4F00_0000, SGL, 1'b0, 64'h0000_0000_7FFF_FFFF, 1'b1, 1'b0, "R4");
    send(64'h41DF_FFFF_FFE0_0000, DBL, 1'b0, 64'h0000_0000_7FFF_FFFF, 1'b1, 1'b0, "R4");
    send(64'h41DF_FFFF_FFA0_0000, DBL, 1'b0, 64'h0000_0000_7FFF_FFFE, 1'b0, 1'b1, "R1");
    send(64'h43E0_0000_0000_0000, DBL, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, "R4");
    send(64'hC3E0_0000_0000_0000, DBL, 1'b1, 64'h8000_0000_0000_0000, 1'b0, 1'b0, "R4");
    send(64'h4630_0000_0000_0000, DBL, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, "R4");
    send(64'h43D0_0000_0000_0000, DBL, 1'b1, 64'h4000_0000_0000_0000, 1'b0, 1'b0, "R4");
    // R2: double and half sources, ignored upper bits
    send(64'h4004_0000_0000_0000, DBL, 1'b1, 64'h2, 1'b0, 1'b1, "R2");
    send(64'hC00C_0000_0000_0000, DBL, 1'b1, 64'hFFFF_FFFF_FFFF_FFFC, 1'b0, 1'b1, "R2");
    send(64'h0000_0000_0000_4100, HLF, 1'b0, 64'h2, 1'b0, 1'b1, "R2");
    send(64'h0000_0000_0000_FBFF, HLF, 1'b0, 64'h0000_0000_FFFF_0020, 1'b0, 1'b0, "R2");
    send(64'hDEAD_BEEF_CAFE_3C00, HLF, 1'b1, 64'h1, 1'b0, 1'b0, "R2");
    send(64'hFFFF_FFFF_3F80_0000, SGL, 1'b1, 64'h1, 1'b0, 1'b0, "R2");
    send(64'h0000_0000_0000_3800, HLF, 1'b0, 64'h0, 1'b0, 1'b1, "R2");
    // R5: NaNs
    send(64'h7FC0_0000, SGL, 1'b1, 64'h0, 1'b1, 1'b0, "R5");
    send(64'h7FF8_0000_0000_0000, DBL, 1'b0, 64'h0, 1'b1, 1'b0, "R5");
    // R6: infinities
    send(64'h7F80_0000, SGL, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, "R6");
    send(64'hFF80_0000, SGL, 1'b0, 64'h0000_0000_8000_0000, 1'b1, 1'b0, "R6");
    send(64'h0000_0000_0000_7C00, HLF, 1'b0, 64'h0000_0000_7FFF_FFFF, 1'b1, 1'b0, "R6");
    // R7: zeros and subnormals
    send(64'h0000_0000, SGL, 1'b1, 64'h0, 1'b0, 1'b0, "R7");
    send(64'h8000_0000, SGL, 1'b1, 64'h0, 1'b0, 1'b0, "R7");
    send(64'h0000_0001, SGL, 1'b0, 64'h0, 1'b0, 1'b1, "R7");
    send(64'h8000_0000_0000_0001, DBL, 1'b1, 64'h0, 1'b0, 1'b1, "R7");
    // R9: unused format code
    send(64'h3F80_0000, RSV, 1'b1, 64'h0, 1'b1, 1'b0, "R9");
    // last one leaves a distinctive value to be held
    send(64'h42CB_0000, SGL, 1'b1, 64'd102, 1'b0, 1'b1, "R10");
    idle(2);

    // R10: output holds while idle, with no valid pulse
    operand = 64'h4060_0000;
    fmt     = SGL;
    idle(4);
    n_checks++;
    if (out_valid !== 1'b0 || result !== last_res || result !== 64'd102) begin
      n_fails++;
      $display("FAIL R10: idle got valid=%b res=%h expected valid=0 res=%h",
               out_valid, result, 64'd102);
    end
    n_checks++;
    if (sb.size() != 0) begin
      n_fails++;
      $display("FAIL R10: %0d results missing, expected 0", sb.size());
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule